// File: doc/BRIEF.md
# Range-Selecting Vector Magnitude Trigger

This block turns a pair of unsigned 15-bit energy components, Ex and Ey, into a coarse vector-sum magnitude and a set of threshold hit bits. It does this with two lookup memories and no arithmetic. Both components are scanned for their highest set bit. That bit picks one of four 6-bit windows, each shifted by one more bit than the last, and the same window is applied to both components. The two windows are joined into a 12-bit address, and the magnitude memory returns a 7-bit magnitude for that address.

The magnitude travels with a 2-bit range code that records the shift used. The range code and the magnitude together form a 9-bit address into a threshold memory. That memory returns eight hit bits, one per programmed threshold, so the range correction is held in the table contents. When an input is too large for the widest window, no overflow flag is sent on. Instead, both windows are forced to all ones at the widest range, which saturates the data itself.

Both memories are loaded through their own write-enable, address and data inputs. A write takes the memory port in its cycle, so tables are loaded while no lookups are in flight. A valid flag travels through the pipeline with the data. There is one register after window selection and one after each lookup, so a result appears three clocks after its inputs.

Top module: `vmt_trigger`

## Requirements
- R1: An input pair presented with `in_valid` high produces exactly one result with `out_valid` high three clock edges later, and `out_valid` is never high without such an input.
- R2: When both inputs are below 64, the range code is 0 and the windows are bits [5:0] of each input.
- R3: When the highest set bit among both inputs is bit 5+r, for r in 1..3, the range code is r and each window is bits [r+5:r] of its own input.
- R4: When either input has any bit from 9 to 14 set, the range code is 3 and both windows are 63.
- R5: The magnitude memory is addressed with the Ex window in address bits [11:6] and the Ey window in bits [5:0], and `out_mag` is the 7-bit entry stored there.
- R6: The threshold memory is addressed with the range code in address bits [8:7] and the magnitude in bits [6:0], and `out_hits` is the 8-bit entry stored there.
- R7: `out_range` carries the range code chosen for the same input pair as `out_mag` and `out_hits`.
- R8: A write with `mag_we` or `thr_we` high stores its data at its address, and every lookup issued after the write sees the new entry.
- R9: While `rst_n` is low, and after it rises until the first valid input has passed through, `out_valid` is low.
- R10: Inputs on consecutive clocks give results on consecutive clocks, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the input pair as valid |
| in_ex | input | 15 | Unsigned x component |
| in_ey | input | 15 | Unsigned y component |
| mag_we | input | 1 | Write enable for the magnitude memory |
| mag_waddr | input | 12 | Magnitude memory write address |
| mag_wdata | input | 7 | Magnitude memory write data |
| thr_we | input | 1 | Write enable for the threshold memory |
| thr_waddr | input | 9 | Threshold memory write address |
| thr_wdata | input | 8 | Threshold memory write data |
| out_valid | output | 1 | Marks the result as valid |
| out_hits | output | 8 | One hit bit per threshold |
| out_mag | output | 7 | Magnitude read from the lookup |
| out_range | output | 2 | Range code that goes with the result |

## Verification
The bench builds the block with its default parameters: 15-bit inputs, 6-bit windows, four ranges, a 7-bit magnitude and eight hit bits. With these values the saturation boundary at bit 9 is reachable, and both full tables load through the write ports in about 4600 clocks. The bench fills the magnitude table with a rounded Euclidean norm. It fills the threshold table from eight thresholds compared against the magnitude scaled by the range. It then drives every range boundary, saturating values, and mixed random traffic with and without gaps. A single magnitude entry is rewritten partway through the run to show that later lookups pick up the new value.

// File: rtl/vmt_pkg.sv
// Package: default sizes shared by the trigger and its submodules.
// Assumes: every module takes these values as parameter defaults only.
package vmt_pkg;
    localparam int VMT_IN_W       = 15; // width of each input component
    localparam int VMT_WIN_W      = 6;  // width of one selected window
    localparam int VMT_NUM_RANGES = 4;  // number of shifted windows
    localparam int VMT_MAG_W      = 7;  // magnitude lookup output width
    localparam int VMT_HIT_W      = 8;  // number of threshold hit bits
endpackage

// File: rtl/vmt_window_sel.sv
// Module: vmt_window_sel
// Finds the highest set bit of the two inputs combined and picks one shifted
// window for both of them. Saturates both windows when the inputs are too
// wide. Registers the joined address, the range code and the valid flag.
// Assumes: IN_W > WIN_W + NUM_RANGES - 1, and the inputs are unsigned.
module vmt_window_sel #(
    parameter int IN_W       = vmt_pkg::VMT_IN_W,
    parameter int WIN_W      = vmt_pkg::VMT_WIN_W,
    parameter int NUM_RANGES = vmt_pkg::VMT_NUM_RANGES,
    parameter int RANGE_W    = $clog2(NUM_RANGES),
    parameter int ADDR_W     = 2 * WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_ex,
    input  logic [IN_W-1:0]    in_ey,
    output logic               s1_valid,
    output logic [ADDR_W-1:0]  s1_addr,
    output logic [RANGE_W-1:0] s1_range
);
    localparam int TOP_W = WIN_W + NUM_RANGES - 1;
    localparam logic [RANGE_W-1:0] MAX_RANGE = RANGE_W'(NUM_RANGES - 1);

    logic [IN_W-1:0]       both;
    logic [NUM_RANGES-1:0] fits;
    logic [RANGE_W-1:0]    sel_range;
    logic                  saturate;
    logic [WIN_W-1:0]      win_ex;
    logic [WIN_W-1:0]      win_ey;
    logic [IN_W-1:0]       shift_ex;
    logic [IN_W-1:0]       shift_ey;

    assign both = in_ex | in_ey;

    // one flag per range: nothing is set above that range's window
    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_fit
        assign fits[r] = ~|(both >> (WIN_W + r));
    end

    // choose the narrowest range that holds both inputs, else saturate
    always_comb begin
        sel_range = MAX_RANGE;
        saturate  = 1'b1;
        for (int r = NUM_RANGES - 1; r >= 0; r--) begin
            if (fits[r]) begin
                sel_range = RANGE_W'(r);
                saturate  = 1'b0;
            end
        end
    end

    // shift each input by the chosen range and cut out the window
    always_comb begin
        shift_ex = in_ex >> sel_range;
        shift_ey = in_ey >> sel_range;
        win_ex   = saturate ? '1 : shift_ex[WIN_W-1:0];
        win_ey   = saturate ? '1 : shift_ey[WIN_W-1:0];
    end

    // valid flag of stage 1, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= in_valid;
    end

    // data of stage 1: joined lookup address and range code
    always_ff @(posedge clk) begin
        s1_addr  <= {win_ex, win_ey};
        s1_range <= sel_range;
    end

    // R2
    small_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ((in_ex >> WIN_W) == '0) && ((in_ey >> WIN_W) == '0)
        |=> s1_range == '0
            && s1_addr == $past({in_ex[WIN_W-1:0], in_ey[WIN_W-1:0]}));

    // R3
    window_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && s1_range != '0 |-> s1_addr[ADDR_W-1] || s1_addr[WIN_W-1]);

    // R4
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (((in_ex >> TOP_W) != '0) || ((in_ey >> TOP_W) != '0))
        |=> s1_range == MAX_RANGE && (&s1_addr));
endmodule

// File: rtl/vmt_lut_ram.sv
// Module: vmt_lut_ram
// Synchronous single-port lookup memory. A write takes the port in its cycle.
// Otherwise the read address is used, and the data is registered one clock
// after the address.
// Assumes: the contents are loaded while no reads are in flight.
module vmt_lut_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 7,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] port_addr;

    // a write takes the single port ahead of a read
    assign port_addr = wr_en ? wr_addr : rd_addr;

    // write the entry, and register the read data
    always_ff @(posedge clk) begin
        if (wr_en) mem[port_addr] <= wr_data;
        rd_data <= mem[port_addr];
    end

    // R8
    write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) && !wr_en && rd_addr == $past(wr_addr)
        |=> rd_data == $past(wr_data, 2));
endmodule

// File: rtl/vmt_trigger.sv
// Module: vmt_trigger
// Top of the vector magnitude trigger. Window selection feeds the magnitude
// memory. The range code goes along with the magnitude into the threshold
// memory, which returns the hit bits. Three register stages in all.
// Assumes: table writes do not happen while lookups are in flight.
module vmt_trigger #(
    parameter int IN_W       = vmt_pkg::VMT_IN_W,
    parameter int WIN_W      = vmt_pkg::VMT_WIN_W,
    parameter int NUM_RANGES = vmt_pkg::VMT_NUM_RANGES,
    parameter int MAG_W      = vmt_pkg::VMT_MAG_W,
    parameter int HIT_W      = vmt_pkg::VMT_HIT_W,
    parameter int RANGE_W    = $clog2(NUM_RANGES),
    parameter int MAG_AW     = 2 * WIN_W,
    parameter int THR_AW     = RANGE_W + MAG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_ex,
    input  logic [IN_W-1:0]    in_ey,
    input  logic               mag_we,
    input  logic [MAG_AW-1:0]  mag_waddr,
    input  logic [MAG_W-1:0]   mag_wdata,
    input  logic               thr_we,
    input  logic [THR_AW-1:0]  thr_waddr,
    input  logic [HIT_W-1:0]   thr_wdata,
    output logic               out_valid,
    output logic [HIT_W-1:0]   out_hits,
    output logic [MAG_W-1:0]   out_mag,
    output logic [RANGE_W-1:0] out_range
);
    logic               s1_valid;
    logic [MAG_AW-1:0]  s1_addr;
    logic [RANGE_W-1:0] s1_range;
    logic               s2_valid;
    logic [RANGE_W-1:0] s2_range;
    logic [MAG_W-1:0]   s2_mag;
    logic [THR_AW-1:0]  thr_raddr;

    vmt_window_sel #(
        .IN_W(IN_W), .WIN_W(WIN_W), .NUM_RANGES(NUM_RANGES),
        .RANGE_W(RANGE_W), .ADDR_W(MAG_AW)
    ) u_sel (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_ex(in_ex), .in_ey(in_ey),
        .s1_valid(s1_valid), .s1_addr(s1_addr), .s1_range(s1_range)
    );

    vmt_lut_ram #(.ADDR_W(MAG_AW), .DATA_W(MAG_W)) u_mag_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(mag_we), .wr_addr(mag_waddr),
        .wr_data(mag_wdata), .rd_addr(s1_addr), .rd_data(s2_mag)
    );

    // stage 2 valid flag, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) s2_valid <= 1'b0;
        else        s2_valid <= s1_valid;
    end

    // carry the range code beside the magnitude lookup
    always_ff @(posedge clk) begin
        s2_range <= s1_range;
    end

    assign thr_raddr = {s2_range, s2_mag};

    vmt_lut_ram #(.ADDR_W(THR_AW), .DATA_W(HIT_W)) u_thr_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(thr_we), .wr_addr(thr_waddr),
        .wr_data(thr_wdata), .rd_addr(thr_raddr), .rd_data(out_hits)
    );

    // stage 3 valid flag, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s2_valid;
    end

    // line up the magnitude and range with the hit bits
    always_ff @(posedge clk) begin
        out_mag   <= s2_mag;
        out_range <= s2_range;
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R7
    range_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_range == $past(s1_range, 2));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/tb_vmt_trigger.sv
module tb_vmt_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [14:0] in_ex = '0;
    logic [14:0] in_ey = '0;
    logic        mag_we = 1'b0;
    logic [11:0] mag_waddr = '0;
    logic [6:0]  mag_wdata = '0;
    logic        thr_we = 1'b0;
    logic [8:0]  thr_waddr = '0;
    logic [7:0]  thr_wdata = '0;
    logic        out_valid;
    logic [7:0]  out_hits;
    logic [6:0]  out_mag;
    logic [1:0]  out_range;

    always #2 clk = ~clk;

    vmt_trigger dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ex(in_ex), .in_ey(in_ey),
        .mag_we(mag_we), .mag_waddr(mag_waddr), .mag_wdata(mag_wdata),
        .thr_we(thr_we), .thr_waddr(thr_waddr), .thr_wdata(thr_wdata),
        .out_valid(out_valid), .out_hits(out_hits), .out_mag(out_mag),
        .out_range(out_range)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int tab_mag [4096];
    int tab_thr [512];
    int thr_lvl [8];
    int lcg = 12345;

    // expected results in flight: index 0 is the newest
    bit e_v [3];
    int e_mag [3];
    int e_rng [3];
    int e_hits [3];
    bit e_sat [3];
    bit e_reload [3];
    bit prev_valid = 0;
    bit in_reset = 1;
    bit reload_mark = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare the outputs with the oldest in-flight entry, then shift in the new one
    task automatic tick(input bit v, input int ex, input int ey);
        int both, rng, addr, m, h;
        bit sat;
        @(negedge clk);
        if (e_v[2]) begin
            check(out_valid === 1'b1, prev_valid ? "R10" : "R1", int'(out_valid), 1);
            check(out_mag === 7'(e_mag[2]), e_reload[2] ? "R8" : "R5", int'(out_mag), e_mag[2]);
            check(out_hits === 8'(e_hits[2]), "R6", int'(out_hits), e_hits[2]);
            check(out_range === 2'(e_rng[2]),
                  e_sat[2] ? "R4" : (e_rng[2] == 0 ? "R2" : "R3"), int'(out_range), e_rng[2]);
            check(out_range === 2'(e_rng[2]), "R7", int'(out_range), e_rng[2]);
        end else begin
            check(out_valid === 1'b0, in_reset ? "R9" : "R1", int'(out_valid), 0);
        end
        prev_valid = e_v[2];
        for (int i = 2; i > 0; i--) begin
            e_v[i] = e_v[i-1]; e_mag[i] = e_mag[i-1]; e_rng[i] = e_rng[i-1];
            e_hits[i] = e_hits[i-1]; e_sat[i] = e_sat[i-1]; e_reload[i] = e_reload[i-1];
        end
        both = ex | ey;
        rng = -1;
        for (int r = 0; r < 4; r++) if (rng < 0 && (both >> (6 + r)) == 0) rng = r;
        sat = (rng < 0);
        if (sat) begin
            rng = 3;
            addr = 4095;
        end else begin
            addr = (((ex >> rng) & 63) << 6) | ((ey >> rng) & 63);
        end
        m = tab_mag[addr];
        h = tab_thr[rng * 128 + m];
        e_v[0] = v && rst_n; e_mag[0] = m; e_rng[0] = rng; e_hits[0] = h;
        e_sat[0] = sat; e_reload[0] = reload_mark;
        in_valid = v;
        in_ex = 15'(ex);
        in_ey = 15'(ey);
        mag_we = 1'b0;
        thr_we = 1'b0;
    endtask

    function automatic int next_rand();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 32'h7fffff;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        $display("FAIL watchdog expired");
        if (!finished) begin
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) thr_lvl[k] = 12 * k * k + 5;
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++) begin
                int m;
                m = $rtoi($sqrt(real'(a * a + b * b)) + 0.5);
                tab_mag[a * 64 + b] = (m > 127) ? 127 : m;
            end
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 128; m++) begin
                int h;
                h = 0;
                for (int k = 0; k < 8; k++) if ((m << r) > thr_lvl[k]) h |= (1 << k);
                tab_thr[r * 128 + m] = h;
            end
        for (int i = 0; i < 3; i++) e_v[i] = 0;

        // R9: reset held with valid inputs presented
        for (int i = 0; i < 4; i++) tick(1, 5, 5);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) e_v[i] = 0;
        idle(3);
        in_reset = 0;

        // R8: load both tables through the write ports
        for (int i = 0; i < 4096; i++) begin
            tick(0, 0, 0);
            mag_we = 1'b1; mag_waddr = 12'(i); mag_wdata = 7'(tab_mag[i]);
        end
        for (int i = 0; i < 512; i++) begin
            tick(0, 0, 0);
            thr_we = 1'b1; thr_waddr = 9'(i); thr_wdata = 8'(tab_thr[i]);
        end
        idle(3);

        // R2 R3 R4: range boundaries and saturation, back to back (R10)
        tick(1, 0, 0);       tick(1, 63, 0);     tick(1, 0, 63);
        tick(1, 64, 0);      tick(1, 0, 64);     tick(1, 127, 127);
        tick(1, 128, 5);     tick(1, 255, 255);  tick(1, 256, 1);
        tick(1, 511, 511);   tick(1, 512, 0);    tick(1, 0, 16384);
        tick(1, 32767, 32767); tick(1, 100, 7);  tick(1, 300, 200);
        tick(1, 3, 385);     tick(1, 1023, 2);
        idle(4);

        // mixed traffic with gaps
        for (int i = 0; i < 1500; i++) begin
            int r, ex, ey, sh;
            r = next_rand();
            sh = (r >> 18) & 3;
            ex = (next_rand() & 63) << sh;
            ey = (next_rand() & 63) << sh;
            if ((r & 31) == 0) ex = next_rand() & 32767;
            tick((r & 3) != 0 || i < 200, ex, ey);
        end
        idle(4);

        // R8: rewrite one magnitude entry, then look it up
        tick(0, 0, 0);
        tab_mag[10 * 64 + 20] = 99;
        mag_we = 1'b1; mag_waddr = 12'(10 * 64 + 20); mag_wdata = 7'd99;
        idle(2);
        reload_mark = 1;
        tick(1, 10, 20);
        tick(1, 20, 40);
        tick(1, 40, 80);
        reload_mark = 0;
        idle(5);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule